// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit bidirectional ports, A and B. Each port is split into an input word, an output word and an output-enable flag, which suits a core-side bus with no tri-state pads. When outputs are enabled, a direction input picks the port that is driven. The driven port carries one of two words, chosen per direction by a select line: the live word from the opposite port's input, or the word held in that direction's storage register.

There are two storage registers, one for A-to-B and one for B-to-A, and each has its own capture clock. Each register samples the resolved value at its source port. That value is the port's own driven word while the port is enabled, and its external input otherwise. The registers keep capturing while both ports are isolated, so a word can be parked in the block and sent out later.

A single active-low reset is applied asynchronously. The reset clears both registers at once and forces both output enables inactive at once. Release is synchronised separately to each capture clock.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are 0 and `a_out` and `b_out` are 0, whatever the other controls are. Both storage registers read back 0 after reset.
- R2: With `oe_n` = 1 (isolation), `a_oe` = `b_oe` = 0 and both output words are 0.
- R3: With `oe_n` = 0, `dir` = 1 drives port B (`b_oe` = 1, `a_oe` = 0), and `dir` = 0 drives port A (`a_oe` = 1, `b_oe` = 0).
- R4: `a_oe` and `b_oe` are never 1 together.
- R5: The live path adds no latency. When B is driven with `sel_ab` = 0, `b_out` equals `a_in` in the same cycle. When A is driven with `sel_ba` = 0, `a_out` equals `b_in` in the same cycle.
- R6: When B is driven with `sel_ab` = 1, `b_out` equals the A-to-B register, independent of `a_in`.
- R7: When A is driven with `sel_ba` = 1, `a_out` equals the B-to-A register, independent of `b_in`.
- R8: The A-to-B register loads on a rising edge of `clk_ab` only. The B-to-A register loads on a rising edge of `clk_ba` only. An edge on one clock leaves the other register unchanged.
- R9: Both registers capture while `oe_n` = 1, and they keep their contents across any input changes that arrive with no capture edge.
- R10: A register whose source port is being driven captures the driven output word, not the external input. The A-to-B register samples `a_out` when `a_oe` = 1. The B-to-A register samples `b_out` when `b_oe` = 1.
- R11: After `rst_n` rises, the first SYNC_STAGES (default 2) rising edges of a capture clock leave its register at 0. The next edge captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir | input | 1 | 1: A feeds B, 0: B feeds A |
| sel_ab | input | 1 | B port source: 0 live A, 1 stored word |
| sel_ba | input | 1 | A port source: 0 live B, 1 stored word |
| a_in | input | WIDTH | External word seen at port A |
| a_out | output | WIDTH | Word driven onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | WIDTH | External word seen at port B |
| b_out | output | WIDTH | Word driven onto port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The enables and the live path are combinational, so those results are due in the same cycle as the control or data change. The bench applies each change and samples 1 ns later, with no capture clock running. A stored word becomes visible only after the single capture edge that loads it. The bench therefore opens a capture clock's gate for exactly one pulse while the clock is low, and reads the register back through the stored path after the falling edge that follows. The reset-release test counts the first two pulses as absorbed by the synchroniser and expects the capture on the third.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    FLOW_B_TO_A = 1'b0,
    FLOW_A_TO_B = 1'b1
  } flow_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];

endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R8
  load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (q == $past(d)));

endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl (
  input  logic arst_n,
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  import xcvr_pkg::*;

  logic  active;
  flow_e flow;

  always_comb begin
    active = arst_n & ~oe_n;
    flow   = flow_e'(dir);
    a_oe   = active & (flow == FLOW_B_TO_A);
    b_oe   = active & (flow == FLOW_A_TO_B);
  end

  // R4
  always_comb begin
    single_driver_chk: assert (!(a_oe && b_oe));
  end

  // R1
  always_comb begin
    if (!arst_n) reset_quiet_chk: assert (!a_oe && !b_oe);
  end

endmodule

// File: rtl/xcvr_port_path.sv
module xcvr_port_path #(
  parameter int WIDTH = 8
) (
  input  logic             drive_en,
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic [WIDTH-1:0] ext_in,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_seen
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] chosen;

  always_comb begin
    chosen    = (src_e'(sel) == SRC_STORED) ? stored : live;
    port_out  = drive_en ? chosen : '0;
    port_seen = drive_en ? port_out : ext_in;
  end

  // R5
  always_comb begin
    if (drive_en && !sel) live_pass_chk: assert (port_out == live);
  end

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam int NDIR = 2;

  logic [NDIR-1:0] cap_clk;
  logic [NDIR-1:0] cap_rst_n;
  logic [WIDTH-1:0] a_seen;
  logic [WIDTH-1:0] b_seen;
  logic [WIDTH-1:0] store_ab;
  logic [WIDTH-1:0] store_ba;

  assign cap_clk = {clk_ba, clk_ab};

  for (genvar g = 0; g < NDIR; g++) begin : g_sync
    xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (cap_clk[g]),
      .arst_n (rst_n),
      .srst_n (cap_rst_n[g])
    );
  end

  xcvr_ctrl u_ctrl (
    .arst_n (rst_n),
    .oe_n   (oe_n),
    .dir    (dir),
    .a_oe   (a_oe),
    .b_oe   (b_oe)
  );

  xcvr_port_path #(.WIDTH(WIDTH)) u_path_b (
    .drive_en  (b_oe),
    .sel       (sel_ab),
    .live      (a_in),
    .stored    (store_ab),
    .ext_in    (b_in),
    .port_out  (b_out),
    .port_seen (b_seen)
  );

  xcvr_port_path #(.WIDTH(WIDTH)) u_path_a (
    .drive_en  (a_oe),
    .sel       (sel_ba),
    .live      (b_in),
    .stored    (store_ba),
    .ext_in    (a_in),
    .port_out  (a_out),
    .port_seen (a_seen)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk   (clk_ab),
    .rst_n (cap_rst_n[0]),
    .d     (a_seen),
    .q     (store_ab)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk   (clk_ba),
    .rst_n (cap_rst_n[1]),
    .d     (b_seen),
    .q     (store_ba)
  );

  // R2
  always_comb begin
    if (oe_n) isolation_chk: assert (!a_oe && !b_oe && a_out == '0 && b_out == '0);
  end

endmodule

// File: tb/dual_path_xcvr_bench.sv
`timescale 1ns/1ps
module dual_path_xcvr_bench;

  logic       clk = 1'b0;
  logic       gate_ab = 1'b0;
  logic       gate_ba = 1'b0;
  logic       rst_n = 1'b0;
  logic       oe_n = 1'b1;
  logic       dir = 1'b0;
  logic       sel_ab = 1'b0;
  logic       sel_ba = 1'b0;
  logic [7:0] a_in = 8'h00;
  logic [7:0] b_in = 8'h00;
  logic [7:0] a_out;
  logic [7:0] b_out;
  logic       a_oe;
  logic       b_oe;
  logic       clk_ab;
  logic       clk_ba;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;
  assign clk_ab = clk & gate_ab;
  assign clk_ba = clk & gate_ba;

  dual_path_xcvr u_dual_path_xcvr (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit ab, input bit ba);
    @(negedge clk);
    gate_ab = ab;
    gate_ba = ba;
    @(negedge clk);
    gate_ab = 1'b0;
    gate_ba = 1'b0;
    #1;
  endtask

  task automatic read_ab(input string tag, input logic [7:0] exp);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
    chk(tag, b_out, exp);
    oe_n = 1'b1; #1;
  endtask

  task automatic read_ba(input string tag, input logic [7:0] exp);
    oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b1; #1;
    chk(tag, a_out, exp);
    oe_n = 1'b1; #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h33; #1;
    chk("R1 b_oe in reset", {7'd0, b_oe}, 8'h00);
    chk("R1 b_out in reset", b_out, 8'h00);
    dir = 1'b0; #1;
    chk("R1 a_oe in reset", {7'd0, a_oe}, 8'h00);
    chk("R1 a_out in reset", a_out, 8'h00);
    tick(1, 1);
    oe_n = 1'b1; a_in = 8'h5A; b_in = 8'hA5;
    @(negedge clk); rst_n = 1'b1; #1;
    tick(1, 1);
    tick(1, 1);
    read_ab("R11 ab held after two edges", 8'h00);
    read_ba("R11 ba held after two edges", 8'h00);
    tick(1, 1);
    read_ab("R11 ab captures third edge", 8'h5A);
    read_ba("R11 ba captures third edge", 8'hA5);
  endtask

  task automatic t_matrix();
    oe_n = 1'b1; a_in = 8'h3C; b_in = 8'hC3;
    tick(1, 1);
    a_in = 8'h11; b_in = 8'h22;
    for (int m = 0; m < 16; m++) begin
      logic ea, eb;
      logic [7:0] xa, xb;
      oe_n = m[3]; dir = m[2]; sel_ab = m[1]; sel_ba = m[0]; #1;
      eb = !m[3] && m[2];
      ea = !m[3] && !m[2];
      xb = eb ? (m[1] ? 8'h3C : 8'h11) : 8'h00;
      xa = ea ? (m[0] ? 8'hC3 : 8'h22) : 8'h00;
      chk("R3 b_oe", {7'd0, b_oe}, {7'd0, eb});
      chk("R3 a_oe", {7'd0, a_oe}, {7'd0, ea});
      chk("R4 single driver", {7'd0, a_oe & b_oe}, 8'h00);
      chk(m[3] ? "R2 b_out isolated" : (m[1] ? "R6 b_out stored" : "R5 b_out live"), b_out, xb);
      chk(m[3] ? "R2 a_out isolated" : (m[0] ? "R7 a_out stored" : "R5 a_out live"), a_out, xa);
    end
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
    a_in = 8'hE7; #1;
    chk("R5 live follows a_in at once", b_out, 8'hE7);
    sel_ab = 1'b1; a_in = 8'h00; #1;
    chk("R6 stored ignores a_in", b_out, 8'h3C);
    dir = 1'b0; sel_ba = 1'b1; b_in = 8'h99; #1;
    chk("R7 stored ignores b_in", a_out, 8'hC3);
    oe_n = 1'b1; #1;
  endtask

  task automatic t_isolation();
    oe_n = 1'b1; a_in = 8'h81; b_in = 8'h18;
    tick(1, 1);
    a_in = 8'hFF; b_in = 8'hFF; #1;
    repeat (3) @(negedge clk);
    read_ab("R9 ab retained across isolation", 8'h81);
    read_ba("R9 ba retained across isolation", 8'h18);
  endtask

  task automatic t_independent();
    oe_n = 1'b1; a_in = 8'h4D; b_in = 8'hD4;
    tick(1, 0);
    read_ab("R8 ab loads on clk_ab", 8'h4D);
    read_ba("R8 ba untouched by clk_ab", 8'h18);
    a_in = 8'h00; b_in = 8'h77;
    tick(0, 1);
    read_ba("R8 ba loads on clk_ba", 8'h77);
    read_ab("R8 ab untouched by clk_ba", 8'h4D);
  endtask

  task automatic t_resolved();
    oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0; b_in = 8'h6E; a_in = 8'h01;
    tick(1, 0);
    read_ab("R10 ab takes driven a_out", 8'h6E);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h97; b_in = 8'h02;
    tick(0, 1);
    read_ba("R10 ba takes driven b_out", 8'h97);
  endtask

  initial begin
    t_reset();
    t_matrix();
    t_isolation();
    t_independent();
    t_resolved();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule